// File: doc/BRIEF.md
# Truth-Table Programmable Ripple ALU

This block is a combinational ALU built from identical bit slices. Each slice looks at three bits: its operand bit from A, its operand bit from B, and a condition bit C that comes from the slice below it. Two 8-bit truth tables are applied to this 3-bit index. One table gives the slice's result bit. The other table gives the C bit for the next slice up. The external carry-in is the C of slice 0, and the carry table output of the top slice leaves the block as carry-out.

The block has no opcode list. The operation is defined only by the pair of tables. One pair gives addition. Another gives subtraction with borrow. Others give a rotate left through carry, a per-bit select steered by the carry-in, or any 3-input Boolean function. Any of the 65,536 code pairs is legal. The outputs depend only on the present inputs and settle within one cycle of the surrounding logic.

Top module: `tt_ripple_alu`

## Requirements
- R1: With the carry table set to 0xAA, every slice sees C equal to the carry-in. In that case result bit i equals bit {A_i,B_i,cin} of the output table. A_i is the most significant bit of this 3-bit index, so index 7 selects the table MSB.
- R2: The carry ripples from bit 0 toward bit 7 only. With carry table 0x00 the carry-out is 0, and with 0xFF it is 1. With output table 0xAA the result is then {7'b0,cin} for 0x00, or 0xFE|cin for 0xFF.
- R3: Output table 0x96 with carry table 0xE8 gives {cout,result} = A + B + cin as a 9-bit sum.
- R4: Output table 0x96 with carry table 0x8E gives {cout,result} = A - B - cin in 9-bit two's complement. cout is the borrow.
- R5: Output table 0xAA with carry table 0xF0 gives result = {A[6:0],cin} and cout = A[7].
- R6: Output table 0xE4 with carry table 0xAA gives result = A when cin is 1 and B when cin is 0, with cout = cin.
- R7: With carry table 0xAA, output tables 0xC0, 0x80, 0xFE and 0x0F give A&B, A&B&{8{cin}}, A|B|{8{cin}} and ~A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 8 | Operand A, the index MSB of each slice |
| opb | input | 8 | Operand B, the middle index bit |
| cin | input | 1 | Condition/carry bit entering slice 0 |
| res_tt | input | 8 | Truth table for the result bit |
| cry_tt | input | 8 | Truth table for the carry passed upward |
| result | output | 8 | Result word |
| cout | output | 1 | Carry produced by the top slice |

## Verification
The hardest case to reach is a carry that must travel the full length of the chain. This happens with an all-ones operand plus a carry-in under the add tables, or a zero minus one under the subtract tables. Random operands seldom produce it. The stimulus therefore adds fixed full-length ripple operands to each arithmetic sweep, for both carry-in values. It also sweeps all 256 output tables under the pass-through carry table, which checks the bit-order convention of the table index directly.

// File: rtl/tt_ripple_alu.sv
module tt_ripple_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  input  logic [7:0]   res_tt,
  input  logic [7:0]   cry_tt,
  output logic [W-1:0] result,
  output logic         cout
);
  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic [2:0] idx;
    assign idx         = {opa[i], opb[i], chain[i]};
    assign result[i]   = res_tt[idx];
    assign chain[i+1]  = cry_tt[idx];
  end

  assign cout = chain[W];
endmodule

// File: rtl/tt_ripple_alu_chk.sv
module tt_ripple_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         cin,
  input logic [7:0]   res_tt,
  input logic [7:0]   cry_tt,
  input logic [W-1:0] result,
  input logic         cout
);
  logic [W:0] sum_ref, dif_ref;
  assign sum_ref = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};
  assign dif_ref = {1'b0, opa} - {1'b0, opb} - {{W{1'b0}}, cin};

  always @(*) begin
    if (res_tt == 8'h96 && cry_tt == 8'hE8)
      AST_ADD_MATCH: assert ({cout, result} == sum_ref); // R3
    if (res_tt == 8'h96 && cry_tt == 8'h8E)
      AST_SUB_MATCH: assert ({cout, result} == dif_ref); // R4
    if (res_tt == 8'hAA && cry_tt == 8'hF0)
      AST_ROTATE_LEFT: assert (result == {opa[W-2:0], cin} && cout == opa[W-1]); // R5
    if (res_tt == 8'hE4 && cry_tt == 8'hAA)
      AST_STEERED_PICK: assert (result == (cin ? opa : opb) && cout == cin); // R6
    if (cry_tt == 8'h00)
      AST_CARRY_LOW: assert (cout == 1'b0); // R2
    if (cry_tt == 8'hFF)
      AST_CARRY_HIGH: assert (cout == 1'b1); // R2
  end
endmodule

bind tt_ripple_alu tt_ripple_alu_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .cin(cin), .res_tt(res_tt), .cry_tt(cry_tt),
  .result(result), .cout(cout)
);

// File: tb/tt_ripple_alu_bench.sv
module tt_ripple_alu_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] opa, opb, res_tt, cry_tt, result;
  logic       cin, cout;

  tt_ripple_alu u_tt_ripple_alu (
    .opa(opa), .opb(opb), .cin(cin), .res_tt(res_tt), .cry_tt(cry_tt),
    .result(result), .cout(cout)
  );

  typedef struct {
    logic [7:0] res;
    logic       co;
    string      req;
  } exp_t;

  exp_t q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic drive(input logic [7:0] a, b, input logic c,
                       input logic [7:0] rt, ct, input logic [7:0] er,
                       input logic eco, input string req);
    exp_t e;
    @(posedge clk);
    #1;
    opa = a; opb = b; cin = c; res_tt = rt; cry_tt = ct;
    e.res = er; e.co = eco; e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (result !== e.res || cout !== e.co) begin
        n_fail++;
        $display("FAIL %s: got res=%h cout=%b, expected res=%h cout=%b",
                 e.req, result, cout, e.res, e.co);
      end
    end
  end

  function automatic logic [7:0] lut_word(input logic [7:0] a, b, input logic c,
                                          input logic [7:0] rt);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = rt[{a[i], b[i], c}];
    return r;
  endfunction

  task automatic arith(input logic [7:0] a, b, input logic c);
    logic [8:0] s, d;
    s = {1'b0, a} + {1'b0, b} + {8'd0, c};
    d = {1'b0, a} - {1'b0, b} - {8'd0, c};
    drive(a, b, c, 8'h96, 8'hE8, s[7:0], s[8], "R3");
    drive(a, b, c, 8'h96, 8'h8E, d[7:0], d[8], "R4");
    drive(a, b, c, 8'hAA, 8'hF0, {a[6:0], c}, a[7], "R5");
    drive(a, b, c, 8'hE4, 8'hAA, c ? a : b, c, "R6");
  endtask

  initial begin
    opa = 0; opb = 0; cin = 0; res_tt = 0; cry_tt = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, "R1 idle");
    for (int t = 0; t < 256; t++) begin
      for (int c = 0; c < 2; c++)
        drive(8'hF0, 8'hCC, c[0], t[7:0], 8'hAA,
              lut_word(8'hF0, 8'hCC, c[0], t[7:0]), c[0], "R1");
    end
    for (int c = 0; c < 2; c++) begin
      drive(8'h5A, 8'hC3, c[0], 8'hAA, 8'h00, {7'd0, c[0]}, 1'b0, "R2 low");
      drive(8'h5A, 8'hC3, c[0], 8'hAA, 8'hFF, 8'hFE | {7'd0, c[0]}, 1'b1, "R2 high");
      arith(8'hFF, 8'h00, c[0]);
      arith(8'hFF, 8'hFF, c[0]);
      arith(8'h00, 8'h01, c[0]);
      arith(8'h80, 8'h80, c[0]);
      for (int k = 0; k < 150; k++)
        arith(8'($urandom), 8'($urandom), c[0]);
    end
    for (int k = 0; k < 40; k++) begin
      logic [7:0] a, b;
      logic c;
      a = 8'($urandom); b = 8'($urandom); c = 1'($urandom);
      drive(a, b, c, 8'hC0, 8'hAA, a & b, c, "R7 and2");
      drive(a, b, c, 8'h80, 8'hAA, a & b & {8{c}}, c, "R7 and3");
      drive(a, b, c, 8'hFE, 8'hAA, a | b | {8{c}}, c, "R7 or3");
      drive(a, b, c, 8'h0F, 8'hAA, ~a, c, "R7 nota");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule